// File: doc/BRIEF.md
# Base-and-Bounds Address Translator

This block sits between a processor's address generation and its memory port and relocates every effective address into physical memory through a single segment. It keeps a relocation base and a segment length. On each access request it checks the effective address against the length, adds the base, and returns either the physical address or a bounds trap that the operating system is expected to service. The result is registered and appears one cycle after the request.

A mode bit adds a two-level privilege scheme. User code can translate through the segment but cannot change it. Supervisor code may rewrite base and length through a small configuration write port. A write attempted in user mode is discarded and raises a one-cycle privilege trap. Entry to supervisor mode is always accepted, since it models trap entry. A drop back to user mode is accepted only from supervisor mode.

Top module: `bbx_translator`

## Requirements
- R1: A request with `req_valid` high is answered on the next cycle with `rsp_valid` high and `rsp_pa` equal to `req_ea` plus the base register, truncated to `ADDR_W` bits, when no trap is raised.
- R2: If `req_ea` is greater than or equal to the length register, the response has `rsp_bound_trap` high and `rsp_pa` forced to zero.
- R3: If `req_ea` plus base carries beyond `ADDR_W` bits, the response has `rsp_bound_trap` high and `rsp_pa` zero, even when the address is inside the length.
- R4: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_pa` and `rsp_bound_trap` are zero.
- R5: `mode_sup` reads 1 in supervisor mode and 0 in user mode. In supervisor mode, a write with `cfg_we` high loads `cfg_wdata` into the base register when `cfg_sel` is 0 and into the length register when `cfg_sel` is 1. Requests issued in any later cycle use the new value.
- R6: A write with `cfg_we` high in user mode changes neither register and drives `priv_trap` high for exactly the following cycle. `priv_trap` is low at all other times.
- R7: In user mode, requests are translated and checked against the current base and length in the same way as in supervisor mode.
- R8: When `mode_set_valid` is high, a `mode_set_val` of 1 enters supervisor mode from either mode. A `mode_set_val` of 0 enters user mode only from supervisor mode and leaves a user-mode block unchanged. The new mode takes effect on the next cycle, and a configuration write in the same cycle is judged by the old mode.
- R9: After reset the block is in supervisor mode, the base is 0, the length is all ones, and `rsp_valid` and `priv_trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | ADDR_W | Effective address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | ADDR_W | Physical address, zero on a trap |
| rsp_bound_trap | output | 1 | Bounds or overflow violation on this response |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Write target: 0 base, 1 length |
| cfg_wdata | input | ADDR_W | Value to write |
| priv_trap | output | 1 | Pulse for a write refused in user mode |
| mode_set_valid | input | 1 | Mode change request strobe |
| mode_set_val | input | 1 | Requested mode: 1 supervisor, 0 user |
| mode_sup | output | 1 | Current mode: 1 supervisor, 0 user |

## Verification
The bench builds the translator with `ADDR_W` set to 5. At that width every combination of base, length and effective address (32 × 32 × 32) can be applied and compared with the sum, the length comparison and the carry worked out in the bench. The sweep therefore reaches every overflow edge and every address equal to or one past the length, not just sample points. The privilege and mode rules are exercised around the sweep: refused user writes are read back through translations, and mode requests are issued from both modes.

// File: rtl/bbx_pkg.sv
// Shared definitions for the base-and-bounds translator.
// Assumes: the mode encoding below is visible at the mode_sup port.
package bbx_pkg;
    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_SUP  = 1'b1
    } bbx_mode_e;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } bbx_sel_e;
endpackage

// File: rtl/bbx_mode_ctrl.sv
// Privilege mode bit.
// Does: holds the mode. Entry to supervisor is always accepted. Return to
//       user is accepted only from supervisor.
// Assumes: synchronous active-low reset into supervisor mode.
module bbx_mode_ctrl
    import bbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_valid,
    input  logic      set_val,
    output bbx_mode_e mode
);
    bbx_mode_e mode_q;
    bbx_mode_e mode_d;

    // Next-mode selection under the privilege rule.
    always_comb begin
        mode_d = mode_q;
        if (set_valid) begin
            if (set_val) begin
                mode_d = MODE_SUP;
            end else if (mode_q == MODE_SUP) begin
                mode_d = MODE_USER;
            end
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SUP;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R8: a supervisor request always lands in supervisor mode.
    a_r8_enter_sup: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_val) |=> (mode_q == MODE_SUP));

    // R8: supervisor mode is never gained without an explicit request.
    a_r8_no_silent_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_USER && !(set_valid && set_val)) |=> (mode_q == MODE_USER));
endmodule

// File: rtl/bbx_seg_regs.sv
// Segment registers: relocation base and segment length.
// Does: takes writes in supervisor mode, refuses them in user mode and
//       pulses a privilege trap one cycle later.
// Assumes: the mode presented is the one in force in the write cycle.
module bbx_seg_regs
    import bbx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bbx_mode_e         mode,
    input  logic              we,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] limit,
    output logic              priv_trap
);
    localparam logic [ADDR_W-1:0] LIMIT_RST = '1;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic              trap_q;
    logic              wr_ok;
    logic              wr_bad;

    // Classify a write by the privilege in force.
    always_comb begin
        wr_ok  = we && (mode == MODE_SUP);
        wr_bad = we && (mode == MODE_USER);
    end

    // Base register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  base_q <= '0;
        else if (wr_ok && bbx_sel_e'(sel) == SEL_BASE) base_q <= wdata;
    end

    // Length register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   limit_q <= LIMIT_RST;
        else if (wr_ok && bbx_sel_e'(sel) == SEL_LIMIT) limit_q <= wdata;
    end

    // Privilege trap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= wr_bad;
    end

    assign base      = base_q;
    assign limit     = limit_q;
    assign priv_trap = trap_q;

    // R6: a user-mode write leaves both registers as they were.
    a_r6_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mode == MODE_USER) |=> ($stable(base_q) && $stable(limit_q)));

    // R6: the trap only follows a write attempted in user mode.
    a_r6_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_q) |-> $past(we && mode == MODE_USER));

    // R5: a supervisor write to the base lands.
    a_r5_base_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mode == MODE_SUP && !sel) |=> (base_q == $past(wdata)));
endmodule

// File: rtl/bbx_xlate.sv
// Registered translation stage.
// Does: compares the effective address with the length, adds the base,
//       detects a carry out, and registers the result with a valid strobe.
// Assumes: base and limit are stable registers from the segment block.
module bbx_xlate #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_trap
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0]  sum;
    logic              over_len;
    logic              carry;
    logic              trap_d;
    logic [ADDR_W-1:0] pa_d;
    logic              vld_q;
    logic              trap_q;
    logic [ADDR_W-1:0] pa_q;

    // Relocation sum and both violation checks.
    always_comb begin
        sum      = {1'b0, req_ea} + {1'b0, base};
        over_len = (req_ea >= limit);
        carry    = sum[SUM_W-1];
        trap_d   = over_len || carry;
        pa_d     = trap_d ? '0 : sum[ADDR_W-1:0];
    end

    // Response register, cleared when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            trap_q <= 1'b0;
            pa_q   <= '0;
        end else begin
            vld_q  <= req_valid;
            trap_q <= req_valid && trap_d;
            pa_q   <= req_valid ? pa_d : '0;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_trap  = trap_q;
    assign rsp_pa    = pa_q;

    // R4: response follows the request by exactly one cycle.
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> vld_q);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!vld_q && !trap_q && pa_q == '0));

    // R2: a trapped response carries no address.
    a_r2_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (vld_q && pa_q == '0));

    // R2: an address at or past the length always traps.
    a_r2_len_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ea >= limit) |=> trap_q);
endmodule

// File: rtl/bbx_translator.sv
// Base-and-bounds address translator, top level.
// Does: relocates effective addresses through one segment, traps bounds
//       violations, and guards the segment registers with a mode bit.
// Assumes: one clock, synchronous active-low reset. Requests use the
//          register values in force in the request cycle.
module bbx_translator
    import bbx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_ea,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_bound_trap,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              priv_trap,
    input  logic              mode_set_valid,
    input  logic              mode_set_val,
    output logic              mode_sup
);
    bbx_mode_e         mode;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;

    bbx_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (mode_set_valid),
        .set_val   (mode_set_val),
        .mode      (mode)
    );

    bbx_seg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .base      (base),
        .limit     (limit),
        .priv_trap (priv_trap)
    );

    bbx_xlate #(.ADDR_W(ADDR_W)) u_xl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ea    (req_ea),
        .base      (base),
        .limit     (limit),
        .rsp_valid (rsp_valid),
        .rsp_pa    (rsp_pa),
        .rsp_trap  (rsp_bound_trap)
    );

    assign mode_sup = (mode == MODE_SUP);

    // R7: a user-mode request is still answered.
    a_r7_user_translates: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_sup) |=> rsp_valid);
endmodule

// File: tb/sim_bbx_translator.sv
module sim_bbx_translator;
    localparam int W = 5;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [W-1:0] req_ea = '0;
    logic         rsp_valid;
    logic [W-1:0] rsp_pa;
    logic         rsp_bound_trap;
    logic         cfg_we = 1'b0;
    logic         cfg_sel = 1'b0;
    logic [W-1:0] cfg_wdata = '0;
    logic         priv_trap;
    logic         mode_set_valid = 1'b0;
    logic         mode_set_val = 1'b0;
    logic         mode_sup;

    int n_chk = 0;
    int n_bad = 0;

    bbx_translator #(.ADDR_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ea(req_ea),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_bound_trap(rsp_bound_trap),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .priv_trap(priv_trap),
        .mode_set_valid(mode_set_valid), .mode_set_val(mode_set_val),
        .mode_sup(mode_sup)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One configuration write; inputs change on the falling edge.
    task automatic cfg_write(input logic sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input logic val);
        @(negedge clk);
        mode_set_valid = 1'b1; mode_set_val = val;
        @(negedge clk);
        mode_set_valid = 1'b0;
    endtask

    // Issue one request and compare the response one cycle later.
    task automatic xlate(input int ea, input int b, input int lim, input string rq);
        int  s;
        bit  tr;
        int  pa;
        s  = ea + b;
        tr = (ea >= lim) || (s >= N);
        pa = tr ? 0 : s;
        @(negedge clk);
        req_valid = 1'b1; req_ea = W'(ea);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {rq, " valid"}, int'(rsp_valid), 1);
        chk(rsp_bound_trap == tr, {rq, " trap"}, int'(rsp_bound_trap), int'(tr));
        chk(int'(rsp_pa) == pa, {rq, " pa"}, int'(rsp_pa), pa);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(mode_sup == 1'b1, "R9 mode", int'(mode_sup), 1);
        chk(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
        chk(priv_trap == 1'b0, "R9 priv_trap", int'(priv_trap), 0);
        xlate(0, 0, N - 1, "R9 base zero");
        xlate(N - 2, 0, N - 1, "R9 top inside");
        xlate(N - 1, 0, N - 1, "R9 length all ones");
        // R4: idle cycle after a response
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_pa == '0 && rsp_bound_trap == 1'b0,
            "R4 idle outputs", int'(rsp_valid), 0);

        // R1 R2 R3 R5: exhaustive sweep in supervisor mode
        for (int b = 0; b < N; b++) begin
            cfg_write(1'b0, b);
            for (int l = 0; l < N; l++) begin
                cfg_write(1'b1, l);
                for (int e = 0; e < N; e++) begin
                    xlate(e, b, l, "R1 R2 R3 R5 sweep");
                end
            end
        end

        // R4: back-to-back requests each answered
        cfg_write(1'b0, 3);
        cfg_write(1'b1, 20);
        @(negedge clk);
        req_valid = 1'b1; req_ea = W'(4);
        @(negedge clk);
        chk(rsp_valid && rsp_pa == W'(7), "R4 first of pair", int'(rsp_pa), 7);
        req_ea = W'(25);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_bound_trap, "R4 second of pair", int'(rsp_bound_trap), 1);

        // R8: drop to user mode
        set_mode(1'b0);
        chk(mode_sup == 1'b0, "R8 to user", int'(mode_sup), 0);
        // R6: refused write, one-cycle trap, registers unchanged
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = W'(9);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(priv_trap == 1'b1, "R6 trap pulse", int'(priv_trap), 1);
        @(negedge clk);
        chk(priv_trap == 1'b0, "R6 trap one cycle", int'(priv_trap), 0);
        cfg_write(1'b1, 2);
        // R7: user translation with unchanged base 3 and length 20
        xlate(10, 3, 20, "R6 R7 user translate");
        xlate(19, 3, 20, "R7 user edge");
        xlate(20, 3, 20, "R7 user bound");
        // R8: user request from user has no effect
        set_mode(1'b0);
        chk(mode_sup == 1'b0, "R8 user stays", int'(mode_sup), 0);
        // R8: same-cycle write judged by old (user) mode
        @(negedge clk);
        mode_set_valid = 1'b1; mode_set_val = 1'b1;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = W'(1);
        @(negedge clk);
        mode_set_valid = 1'b0; cfg_we = 1'b0;
        chk(mode_sup == 1'b1, "R8 enter sup", int'(mode_sup), 1);
        chk(priv_trap == 1'b1, "R8 old mode judges write", int'(priv_trap), 1);
        xlate(5, 3, 20, "R8 base kept");
        // R8: supervisor request from supervisor keeps supervisor
        set_mode(1'b1);
        chk(mode_sup == 1'b1, "R8 sup stays", int'(mode_sup), 1);
        // R5: supervisor write has no trap and takes effect
        cfg_write(1'b0, 6);
        chk(priv_trap == 1'b0, "R5 no trap", int'(priv_trap), 0);
        xlate(5, 6, 20, "R5 new base");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule